// File: doc/BRIEF.md
# Bridge Forwarding Window Decoder

This block decides, for a bridge between an upstream and a downstream bus, whether a transaction address belongs downstream. It holds no configuration state of its own: the raw I/O, memory and prefetchable-memory base and limit fields arrive as inputs, together with their upper extensions, the command-register enables and the bridge's VGA forwarding enable. The decoder turns each pair of packed fields into a full 64-bit window and compares the request address against the window for its address space.

A request is presented with `req_valid`, an address, a space select (I/O or memory) and a prefetchable tag. One clock later the block returns the verdict. It reports whether to forward, which window matched, and separately whether the address falls in one of the legacy VGA ranges while VGA forwarding is on. Every window is gated by its command enable. A window whose limit lies below its base is empty.

Top module: `bridge_window_decoder`

## Requirements
- R1: The I/O window base is `io_base_reg[7:4]` placed at address bits 15:12 with bits 11:0 zero. The limit is `io_limit_reg[7:4]` at bits 15:12 with bits 11:0 all ones. When a register's low nibble equals 1 (32-bit I/O), its 16-bit upper register supplies bits 31:16. Otherwise those bits are zero. Only requests with `req_is_io`=1 are checked against this window.
- R2: The memory window base is `mem_base_reg[15:4]` at address bits 31:20 with bits 19:0 zero. The limit is `mem_limit_reg[15:4]` at bits 31:20 with bits 19:0 all ones. Bits 63:32 of both bounds are zero.
- R3: The prefetchable window is built like the memory window from `pf_base_reg` and `pf_limit_reg`. When a register's low nibble equals 1 (64-bit), its 32-bit upper register supplies bits 63:32. Otherwise those bits are zero.
- R4: The I/O window matches only while `cmd_io_en`=1. Both memory windows match only while `cmd_mem_en`=1.
- R5: An address matches a window when base <= address <= limit. A window whose limit is below its base matches nothing.
- R6: `fwd_win` encodes 0 = none, 1 = I/O, 2 = memory, 3 = prefetchable. A memory request that hits both memory windows reports 3 if tagged prefetchable and 2 otherwise. A request hitting only one window reports that window.
- R7: While `vga_en`=1, `vga_hit` is set for memory addresses 0xA0000 to 0xBFFFF and for I/O addresses 0x3B0 to 0x3BB and 0x3C0 to 0x3DF. While `vga_en`=0, `vga_hit` stays 0.
- R8: In 16-bit I/O mode, an I/O address with any bit above bit 15 set never matches the I/O window.
- R9: `fwd_valid` follows `req_valid` by exactly one clock. `fwd_hit` is set when `fwd_win` is not 0 or `vga_hit` is set. `fwd_hit`, `fwd_win` and `vga_hit` are all 0 whenever `fwd_valid` is 0.
- R10: While `rst` is high, and on the first cycle after it, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_base_reg | input | 8 | I/O base field: bits 7:4 address, bits 3:0 type |
| io_limit_reg | input | 8 | I/O limit field: bits 7:4 address, bits 3:0 type |
| io_base_up | input | 16 | I/O base address bits 31:16 |
| io_limit_up | input | 16 | I/O limit address bits 31:16 |
| mem_base_reg | input | 16 | Memory base field, bits 15:4 used |
| mem_limit_reg | input | 16 | Memory limit field, bits 15:4 used |
| pf_base_reg | input | 16 | Prefetchable base field: bits 15:4 address, bits 3:0 type |
| pf_limit_reg | input | 16 | Prefetchable limit field: bits 15:4 address, bits 3:0 type |
| pf_base_up | input | 32 | Prefetchable base address bits 63:32 |
| pf_limit_up | input | 32 | Prefetchable limit address bits 63:32 |
| cmd_io_en | input | 1 | I/O space enable |
| cmd_mem_en | input | 1 | Memory space enable |
| vga_en | input | 1 | Legacy VGA forwarding enable |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 64 | Request address |
| req_is_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_prefetch | input | 1 | Request tagged prefetchable |
| fwd_valid | output | 1 | Verdict present |
| fwd_hit | output | 1 | Forward downstream |
| fwd_win | output | 2 | Matched window code |
| vga_hit | output | 1 | Legacy VGA range hit |

## Verification
Several checks run on every cycle. The one-cycle latency of the verdict is checked. Quiet outputs are required whenever no verdict is present. The I/O and memory verdicts are checked against the enables sampled with the request. A VGA hit is checked against the VGA enable. A reported window must be non-empty. Other behaviour can only be shown by the bench's scenarios. This covers the exact bound arithmetic at each window edge, the granularity fill, the switch between short and extended decoding and the rejection of high I/O addresses. It also covers the choice between overlapping memory windows and the exact edges of the VGA ranges.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

    localparam int ADDR_W = 64;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_IO   = 2'd1,
        WIN_MEM  = 2'd2,
        WIN_PREF = 2'd3
    } win_e;

    typedef struct packed {
        addr_t lo;
        addr_t hi;
    } bounds_t;

    typedef struct packed {
        logic valid;
        logic hit;
        win_e win;
        logic vga;
    } result_t;

    // Type nibble value that enables the upper extension
    localparam logic [3:0] EXT_TYPE = 4'h1;

    // Legacy display ranges
    localparam addr_t VGA_MEM_LO  = 64'h000A_0000;
    localparam addr_t VGA_MEM_HI  = 64'h000B_FFFF;
    localparam addr_t VGA_IO_A_LO = 64'h0000_03B0;
    localparam addr_t VGA_IO_A_HI = 64'h0000_03BB;
    localparam addr_t VGA_IO_B_LO = 64'h0000_03C0;
    localparam addr_t VGA_IO_B_HI = 64'h0000_03DF;

    function automatic logic in_span(addr_t a, addr_t lo, addr_t hi);
        return (a >= lo) && (a <= hi);
    endfunction

    function automatic win_e pick_window(logic io_hit, logic mem_hit,
                                         logic pf_hit, logic prefetch);
        if (io_hit)
            return WIN_IO;
        else if (pf_hit && (prefetch || !mem_hit))
            return WIN_PREF;
        else if (mem_hit)
            return WIN_MEM;
        else
            return WIN_NONE;
    endfunction

endpackage

// File: rtl/bwd_bounds.sv
module bwd_bounds
    import bwd_pkg::*;
#(
    parameter int REG_W     = 16,
    parameter int GRAN_BITS = 20,
    parameter int UP_W      = 32,
    parameter int UP_LSB    = 32,
    parameter bit HAS_UP    = 1'b1
) (
    input  logic [REG_W-1:0] base_reg,
    input  logic [REG_W-1:0] lim_reg,
    input  logic [UP_W-1:0]  base_up,
    input  logic [UP_W-1:0]  lim_up,
    output bounds_t          bnd
);
    localparam int    FIELD_W = REG_W - 4;
    localparam addr_t FILL    = (addr_t'(1) << GRAN_BITS) - addr_t'(1);

    addr_t base_low, lim_low;

    always_comb begin
        base_low = addr_t'(base_reg[REG_W-1:4]) << GRAN_BITS;
        lim_low  = (addr_t'(lim_reg[REG_W-1:4]) << GRAN_BITS) | FILL;
    end

    generate
        if (HAS_UP) begin : g_ext
            logic base_ext, lim_ext;
            always_comb begin
                base_ext = (base_reg[3:0] == EXT_TYPE);
                lim_ext  = (lim_reg[3:0]  == EXT_TYPE);
                bnd.lo = base_low | (base_ext ? (addr_t'(base_up) << UP_LSB) : '0);
                bnd.hi = lim_low  | (lim_ext  ? (addr_t'(lim_up)  << UP_LSB) : '0);
            end
        end else begin : g_flat
            logic unused_bits;
            always_comb begin
                unused_bits = ^{base_up, lim_up, base_reg[3:0], lim_reg[3:0]};
                bnd.lo = base_low;
                bnd.hi = lim_low;
            end
        end
    endgenerate

    initial begin
        if (FIELD_W + GRAN_BITS > ADDR_W) $error("bwd_bounds: field exceeds address");
    end

endmodule

// File: rtl/bwd_range.sv
module bwd_range
    import bwd_pkg::*;
(
    input  logic    en,
    input  bounds_t bnd,
    input  addr_t   addr,
    output logic    hit
);
    logic nonempty;

    always_comb begin
        nonempty = (bnd.lo <= bnd.hi);
        hit      = en && nonempty && in_span(addr, bnd.lo, bnd.hi);
    end

endmodule

// File: rtl/bwd_vga.sv
module bwd_vga
    import bwd_pkg::*;
(
    input  logic  en,
    input  logic  is_io,
    input  addr_t addr,
    output logic  hit
);
    always_comb begin
        if (!en)
            hit = 1'b0;
        else if (is_io)
            hit = in_span(addr, VGA_IO_A_LO, VGA_IO_A_HI) ||
                  in_span(addr, VGA_IO_B_LO, VGA_IO_B_HI);
        else
            hit = in_span(addr, VGA_MEM_LO, VGA_MEM_HI);
    end

endmodule

// File: rtl/bridge_window_decoder.sv
module bridge_window_decoder
    import bwd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  io_base_reg,
    input  logic [7:0]  io_limit_reg,
    input  logic [15:0] io_base_up,
    input  logic [15:0] io_limit_up,
    input  logic [15:0] mem_base_reg,
    input  logic [15:0] mem_limit_reg,
    input  logic [15:0] pf_base_reg,
    input  logic [15:0] pf_limit_reg,
    input  logic [31:0] pf_base_up,
    input  logic [31:0] pf_limit_up,
    input  logic        cmd_io_en,
    input  logic        cmd_mem_en,
    input  logic        vga_en,
    input  logic        req_valid,
    input  logic [63:0] req_addr,
    input  logic        req_is_io,
    input  logic        req_prefetch,
    output logic        fwd_valid,
    output logic        fwd_hit,
    output logic [1:0]  fwd_win,
    output logic        vga_hit
);
    bounds_t io_bnd, mem_bnd, pf_bnd;
    logic    io_hit_raw, mem_hit_raw, pf_hit_raw, vga_raw;
    logic    io_hit, mem_hit, pf_hit;
    result_t nxt, res_q;

    bwd_bounds #(.REG_W(8), .GRAN_BITS(12), .UP_W(16), .UP_LSB(16), .HAS_UP(1'b1)) u_io_bnd (
        .base_reg(io_base_reg), .lim_reg(io_limit_reg),
        .base_up(io_base_up), .lim_up(io_limit_up), .bnd(io_bnd));

    bwd_bounds #(.REG_W(16), .GRAN_BITS(20), .UP_W(1), .UP_LSB(32), .HAS_UP(1'b0)) u_mem_bnd (
        .base_reg(mem_base_reg), .lim_reg(mem_limit_reg),
        .base_up(1'b0), .lim_up(1'b0), .bnd(mem_bnd));

    bwd_bounds #(.REG_W(16), .GRAN_BITS(20), .UP_W(32), .UP_LSB(32), .HAS_UP(1'b1)) u_pf_bnd (
        .base_reg(pf_base_reg), .lim_reg(pf_limit_reg),
        .base_up(pf_base_up), .lim_up(pf_limit_up), .bnd(pf_bnd));

    bwd_range u_io_rng  (.en(cmd_io_en),  .bnd(io_bnd),  .addr(req_addr), .hit(io_hit_raw));
    bwd_range u_mem_rng (.en(cmd_mem_en), .bnd(mem_bnd), .addr(req_addr), .hit(mem_hit_raw));
    bwd_range u_pf_rng  (.en(cmd_mem_en), .bnd(pf_bnd),  .addr(req_addr), .hit(pf_hit_raw));

    bwd_vga u_vga (.en(vga_en), .is_io(req_is_io), .addr(req_addr), .hit(vga_raw));

    always_comb begin
        io_hit  = req_is_io  && io_hit_raw;
        mem_hit = !req_is_io && mem_hit_raw;
        pf_hit  = !req_is_io && pf_hit_raw;
        nxt       = '0;
        nxt.valid = req_valid;
        if (req_valid) begin
            nxt.win = pick_window(io_hit, mem_hit, pf_hit, req_prefetch);
            nxt.vga = vga_raw;
            nxt.hit = (nxt.win != WIN_NONE) || vga_raw;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= nxt;
    end

    assign fwd_valid = res_q.valid;
    assign fwd_hit   = res_q.hit;
    assign fwd_win   = res_q.win;
    assign vga_hit   = res_q.vga;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> fwd_valid); // R9
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !fwd_valid); // R9
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        !fwd_valid |-> (!fwd_hit && !vga_hit && fwd_win == 2'd0)); // R9
    AST_IO_GATED: assert property (@(posedge clk) disable iff (rst)
        (fwd_win == 2'd1) |-> $past(cmd_io_en)); // R4
    AST_MEM_GATED: assert property (@(posedge clk) disable iff (rst)
        (fwd_win[1]) |-> $past(cmd_mem_en)); // R4
    AST_VGA_GATED: assert property (@(posedge clk) disable iff (rst)
        vga_hit |-> $past(vga_en)); // R7
    AST_IO_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        (fwd_win == 2'd1) |-> $past(io_bnd.lo <= io_bnd.hi)); // R5
    AST_MEM_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        (fwd_win == 2'd2) |-> $past(mem_bnd.lo <= mem_bnd.hi)); // R5

endmodule

// File: tb/sim_bridge_window_decoder.sv
module sim_bridge_window_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  io_base_reg = '0, io_limit_reg = '0;
    logic [15:0] io_base_up = '0, io_limit_up = '0;
    logic [15:0] mem_base_reg = '0, mem_limit_reg = '0;
    logic [15:0] pf_base_reg = '0, pf_limit_reg = '0;
    logic [31:0] pf_base_up = '0, pf_limit_up = '0;
    logic        cmd_io_en = 1'b0, cmd_mem_en = 1'b0, vga_en = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic        req_is_io = 1'b0, req_prefetch = 1'b0;
    logic        fwd_valid, fwd_hit, vga_hit;
    logic [1:0]  fwd_win;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [1:0] win;
        logic       vga;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    bridge_window_decoder u0 (.*);

    task automatic fail_line(string tag, string what, int act, int exp_v);
        n_bad++;
        $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp_v);
    endtask

    task automatic send(logic [63:0] a, logic io, logic pf,
                        logic [1:0] ew, logic ev, string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_is_io = io; req_prefetch = pf;
        e.win = ew; e.vga = ev; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; req_addr = '0; req_is_io = 1'b0; req_prefetch = 1'b0;
    endtask

    // Monitor: compare each verdict with the head of the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && fwd_valid) begin
                exp_t e;
                n_vec++;
                if (sb.size() == 0) begin
                    fail_line("R9", "unexpected verdict", 1, 0);
                end else begin
                    logic eh;
                    e = sb.pop_front();
                    eh = (e.win != 2'd0) || e.vga;
                    if (fwd_win !== e.win) fail_line(e.tag, "fwd_win", int'(fwd_win), int'(e.win));
                    else if (vga_hit !== e.vga) fail_line(e.tag, "vga_hit", int'(vga_hit), int'(e.vga));
                    else if (fwd_hit !== eh) fail_line(e.tag, "fwd_hit R9", int'(fwd_hit), int'(eh));
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        n_vec++;
        if (fwd_valid !== 1'b0 || fwd_hit !== 1'b0 || fwd_win !== 2'd0 || vga_hit !== 1'b0)
            fail_line("R10", "outputs in reset", int'({fwd_valid, fwd_hit, fwd_win, vga_hit}), 0);
        req_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        n_vec++;
        if (fwd_valid !== 1'b0 || fwd_hit !== 1'b0)
            fail_line("R10", "first cycle after reset", int'({fwd_valid, fwd_hit}), 0);

        // Configuration A: 16-bit I/O, 32-bit pref with 64-bit upper
        io_base_reg = 8'h20; io_limit_reg = 8'h30;            // 0x2000..0x3FFF
        mem_base_reg = 16'h1000; mem_limit_reg = 16'h1FF0;    // 0x1000_0000..0x1FFF_FFFF
        pf_base_reg = 16'h2001; pf_limit_reg = 16'h2FF1;
        pf_base_up = 32'h1; pf_limit_up = 32'h1;              // 0x1_2000_0000..0x1_2FFF_FFFF
        cmd_io_en = 1'b1; cmd_mem_en = 1'b1;
        send(64'h2000, 1, 0, 2'd1, 0, "R1");
        send(64'h1FFF, 1, 0, 2'd0, 0, "R1");
        send(64'h3FFF, 1, 0, 2'd1, 0, "R1");
        send(64'h4000, 1, 0, 2'd0, 0, "R1");
        send(64'h1_2000, 1, 0, 2'd0, 0, "R8");
        send(64'h1_0000_3000, 1, 0, 2'd0, 0, "R8");
        send(64'h1000_0000, 1, 0, 2'd0, 0, "R1");
        send(64'h1000_0000, 0, 0, 2'd2, 0, "R2");
        send(64'h1FFF_FFFF, 0, 0, 2'd2, 0, "R2");
        send(64'h2000_0000, 0, 0, 2'd0, 0, "R2");
        send(64'h0FFF_FFFF, 0, 0, 2'd0, 0, "R2");
        send(64'h1_2000_0000, 0, 1, 2'd3, 0, "R3");
        send(64'h1_2FFF_FFFF, 0, 0, 2'd3, 0, "R3");
        send(64'h1_3000_0000, 0, 1, 2'd0, 0, "R3");
        send(64'h2800_0000, 0, 1, 2'd0, 0, "R3");
        idle();
        @(negedge clk);
        n_vec++;
        if (fwd_valid !== 1'b0 || fwd_hit !== 1'b0)
            fail_line("R9", "idle verdict", int'({fwd_valid, fwd_hit}), 0);

        // Configuration B: 32-bit I/O, overlapping 32-bit pref window
        io_base_reg = 8'h21; io_limit_reg = 8'h21;
        io_base_up = 16'h0001; io_limit_up = 16'h0001;       // 0x1_2000..0x1_2FFF
        pf_base_reg = 16'h1000; pf_limit_reg = 16'h10F0;      // 0x1000_0000..0x10FF_FFFF
        pf_base_up = 32'h5; pf_limit_up = 32'h5;              // ignored: not 64-bit
        send(64'h1_2ABC, 1, 0, 2'd1, 0, "R1");
        send(64'h1_2FFF, 1, 0, 2'd1, 0, "R1");
        send(64'h2ABC, 1, 0, 2'd0, 0, "R1");
        send(64'h1080_0000, 0, 1, 2'd3, 0, "R6");
        send(64'h1080_0000, 0, 0, 2'd2, 0, "R6");
        send(64'h1100_0000, 0, 1, 2'd2, 0, "R6");
        send(64'h5_1000_0000, 0, 1, 2'd0, 0, "R3");

        // Enables off
        idle();
        cmd_io_en = 1'b0;
        send(64'h1_2000, 1, 0, 2'd0, 0, "R4");
        send(64'h1000_0000, 0, 0, 2'd2, 0, "R4");
        idle();
        cmd_io_en = 1'b1; cmd_mem_en = 1'b0;
        send(64'h1000_0000, 0, 0, 2'd0, 0, "R4");
        send(64'h1080_0000, 0, 1, 2'd0, 0, "R4");
        send(64'h1_2000, 1, 0, 2'd1, 0, "R4");

        // Empty and single-granule windows
        idle();
        cmd_mem_en = 1'b1;
        mem_base_reg = 16'h2000; mem_limit_reg = 16'h1000;
        pf_base_reg = 16'h4000; pf_limit_reg = 16'h3000;
        send(64'h1800_0000, 0, 0, 2'd0, 0, "R5");
        send(64'h2000_0000, 0, 0, 2'd0, 0, "R5");
        send(64'h1000_0000, 0, 0, 2'd0, 0, "R5");
        send(64'h4000_0000, 0, 1, 2'd0, 0, "R5");
        idle();
        mem_base_reg = 16'h3000; mem_limit_reg = 16'h3000;   // 0x3000_0000..0x300F_FFFF
        send(64'h300F_FFFF, 0, 0, 2'd2, 0, "R5");
        send(64'h3010_0000, 0, 0, 2'd0, 0, "R5");

        // Legacy VGA ranges
        idle();
        vga_en = 1'b1;
        send(64'hA0000, 0, 0, 2'd0, 1, "R7");
        send(64'hBFFFF, 0, 0, 2'd0, 1, "R7");
        send(64'hC0000, 0, 0, 2'd0, 0, "R7");
        send(64'h9FFFF, 0, 0, 2'd0, 0, "R7");
        send(64'h3BB, 1, 0, 2'd0, 1, "R7");
        send(64'h3BC, 1, 0, 2'd0, 0, "R7");
        send(64'h3C0, 1, 0, 2'd0, 1, "R7");
        send(64'h3DF, 1, 0, 2'd0, 1, "R7");
        send(64'h3E0, 1, 0, 2'd0, 0, "R7");
        send(64'h3C0, 0, 0, 2'd0, 0, "R7");
        idle();
        vga_en = 1'b0;
        send(64'h3C0, 1, 0, 2'd0, 0, "R7");
        send(64'hA0000, 0, 0, 2'd0, 0, "R7");
        idle();
        repeat (3) @(negedge clk);

        n_vec++;
        if (sb.size() != 0) fail_line("R9", "missing verdicts", sb.size(), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule